// File: doc/BRIEF.md
# Fault Protection Auto-Restart Sequencer

This block sits between the fault comparators of a switching LED driver and its gate logic. It watches three fault sources: an over-voltage flag on the controller supply, an over-current flag from the switch current sense, and an over-temperature flag. A fault of any kind stops switching in the same cycle. The block then holds the converter off for a fixed auto-restart interval. When that interval ends, it releases switching and raises a one-cycle soft-start request, so the ramp logic can bring the current back up gently.

Over-current is acted on only after the gate has been on for a leading-edge blanking window. This masks the turn-on spike.

A thermal trip is handled differently from the other faults. The block enters a thermal lockout. At the end of every auto-restart interval it samples a "cool enough" flag, which the comparator asserts once the temperature is below the trip point minus its hysteresis. It restarts only if that flag is high; otherwise it starts another interval.

Every fault seen is recorded in a sticky status vector that a clear strobe empties. A fault code reports the most severe recorded fault.

Top module: `fault_restart_seq`

## Requirements
- R1: `sw_stop_o` is high in any cycle in which `ovp_i`, `temp_hot_i` or a qualified over-current is present, with no register in that path. It is also high in every cycle the block is in a hold-off or thermal lockout.
- R2: `ocp_raw_i` qualifies only once `gate_on_i` has been sampled high on `LEB_CYC` consecutive clock edges. The blanking count restarts whenever `gate_on_i` is sampled low.
- R3: After a clock edge that samples `ovp_i` or a qualified over-current while running, switching stays stopped for exactly `AR_CYC` further cycles, provided no new fault arrives.
- R4: When a hold-off or lockout ends in a restart, `ss_req_o` is high for exactly one cycle: the first cycle in which the block is running again.
- R5: A supply over-voltage or qualified over-current sampled during a hold-off or thermal lockout reloads the interval. The stop then lasts `AR_CYC` cycles counted from that last fault edge.
- R6: `temp_hot_i` takes precedence over the other faults and enters thermal lockout, shown on `therm_hold_o`. At each interval expiry the block restarts if `temp_cool_i` is high; otherwise it begins a new interval and stays locked out.
- R7: `fault_sts_o` is sticky, with bit 0 for over-current, bit 1 for supply over-voltage and bit 2 for over-temperature. A bit is set on any cycle its fault is sampled, and all bits clear on `sts_clr_i`. A fault sampled in the same cycle as the clear still sets its bit.
- R8: `fault_code_o` gives the most severe recorded fault from `fault_sts_o`: 3 for over-temperature, otherwise 2 for over-voltage, otherwise 1 for over-current, otherwise 0.
- R9: After reset the block is running with `ss_req_o`, `therm_hold_o`, `fault_sts_o` and `fault_code_o` all zero. With no fault input present, `sw_stop_o` is also low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| ovp_i | input | 1 | Supply over-voltage comparator flag |
| gate_on_i | input | 1 | Power switch gate currently driven on |
| ocp_raw_i | input | 1 | Switch current sense above over-current threshold (unblanked) |
| temp_hot_i | input | 1 | Die temperature above thermal trip level |
| temp_cool_i | input | 1 | Die temperature below trip level minus hysteresis |
| sts_clr_i | input | 1 | Clear strobe for the sticky status vector |
| sw_stop_o | output | 1 | Switching must stop |
| ss_req_o | output | 1 | One-cycle soft-start request on restart |
| therm_hold_o | output | 1 | Thermal lockout in progress |
| fault_sts_o | output | 3 | Sticky fault flags {over-temp, over-voltage, over-current} |
| fault_code_o | output | 2 | Most severe recorded fault |

## Verification
The properties assume that the two thermal flags are never high together. Real hysteresis comparators cannot report both "above trip" and "below release". The properties also assume that the over-current sense is only meaningful while the gate is on.

The stimulus keeps the hot and cool flags mutually exclusive. It changes inputs a short time after each rising edge, so every flag is sampled on a well-defined edge. It drives the over-current sense only together with the gate signal, and it deliberately tests pulses both shorter and longer than the blanking window.

// File: rtl/fpr_pkg.sv
package fpr_pkg;

  typedef enum logic [1:0] {
    ST_RUN   = 2'd0,
    ST_HOLD  = 2'd1,
    ST_THERM = 2'd2
  } seq_state_e;

  typedef enum logic [1:0] {
    FC_NONE = 2'd0,
    FC_OCP  = 2'd1,
    FC_OVP  = 2'd2,
    FC_OTP  = 2'd3
  } fault_code_e;

  localparam int unsigned FLAG_N  = 3;
  localparam int unsigned BIT_OCP = 0;
  localparam int unsigned BIT_OVP = 1;
  localparam int unsigned BIT_OTP = 2;

endpackage

// File: rtl/fpr_rst_sync.sv
module fpr_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= 2'b00;
    end else begin
      sync_q <= {sync_q[0], 1'b1};
    end
  end

  assign rst_sync_n = sync_q[1];

endmodule

// File: rtl/fpr_blank.sv
module fpr_blank #(
  parameter int unsigned LEB_CYC = 40
) (
  input  logic clk,
  input  logic rst_n,
  input  logic gate_on_i,
  input  logic ocp_raw_i,
  output logic ocp_q_o
);

  localparam int unsigned CW = $clog2(LEB_CYC + 1);
  localparam logic [CW-1:0] CNT_SAT = CW'(LEB_CYC);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] cnt_d;
  logic          cnt_en;

  // Count gate-on edges, saturating at the blanking length.
  always_comb begin
    cnt_en = !gate_on_i || (cnt_q != CNT_SAT);
    cnt_d  = gate_on_i ? (cnt_q + 1'b1) : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  assign ocp_q_o = gate_on_i & ocp_raw_i & (cnt_q == CNT_SAT);

endmodule

// File: rtl/fpr_timer.sv
module fpr_timer #(
  parameter int unsigned AR_CYC = 100_000_000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load_i,
  output logic expired_o
);

  localparam int unsigned TW = (AR_CYC > 1) ? $clog2(AR_CYC) : 1;
  localparam logic [TW-1:0] LOAD_VAL = TW'(AR_CYC - 1);

  logic [TW-1:0] cnt_q;
  logic [TW-1:0] cnt_d;
  logic          cnt_en;

  always_comb begin
    cnt_en = load_i || (cnt_q != '0);
    cnt_d  = load_i ? LOAD_VAL : (cnt_q - 1'b1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  assign expired_o = (cnt_q == '0);

endmodule

// File: rtl/fpr_status.sv
module fpr_status
  import fpr_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [FLAG_N-1:0] flags_i,
  input  logic              clr_i,
  output logic [FLAG_N-1:0] sts_o,
  output logic [1:0]        code_o
);

  logic [FLAG_N-1:0] sts_q;
  logic [FLAG_N-1:0] sts_d;
  logic              sts_en;
  fault_code_e       code;

  // A flag seen in the clearing cycle survives the clear.
  always_comb begin
    sts_en = clr_i || (|flags_i);
    sts_d  = (clr_i ? '0 : sts_q) | flags_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sts_q <= '0;
    end else if (sts_en) begin
      sts_q <= sts_d;
    end
  end

  // Later tests win: most severe fault checked last.
  always_comb begin
    code = FC_NONE;
    if (sts_q[BIT_OCP]) code = FC_OCP;
    if (sts_q[BIT_OVP]) code = FC_OVP;
    if (sts_q[BIT_OTP]) code = FC_OTP;
  end

  assign sts_o  = sts_q;
  assign code_o = code;

endmodule

// File: rtl/fault_restart_seq.sv
module fault_restart_seq
  import fpr_pkg::*;
#(
  parameter int unsigned LEB_CYC = 40,
  parameter int unsigned AR_CYC  = 100_000_000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ovp_i,
  input  logic       gate_on_i,
  input  logic       ocp_raw_i,
  input  logic       temp_hot_i,
  input  logic       temp_cool_i,
  input  logic       sts_clr_i,
  output logic       sw_stop_o,
  output logic       ss_req_o,
  output logic       therm_hold_o,
  output logic [2:0] fault_sts_o,
  output logic [1:0] fault_code_o
);

  logic              rst_sync_n;
  logic              ocp_q;
  logic              trip;
  logic              expired;
  logic              load;
  logic              ss_d;
  logic              ss_q;
  logic [FLAG_N-1:0] flags;
  seq_state_e        st_q;
  seq_state_e        st_d;

  fpr_rst_sync u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  fpr_blank #(.LEB_CYC(LEB_CYC)) u_blank (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .gate_on_i (gate_on_i),
    .ocp_raw_i (ocp_raw_i),
    .ocp_q_o   (ocp_q)
  );

  fpr_timer #(.AR_CYC(AR_CYC)) u_timer (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .load_i    (load),
    .expired_o (expired)
  );

  always_comb begin
    flags          = '0;
    flags[BIT_OCP] = ocp_q;
    flags[BIT_OVP] = ovp_i;
    flags[BIT_OTP] = temp_hot_i;
  end

  fpr_status u_status (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .flags_i (flags),
    .clr_i   (sts_clr_i),
    .sts_o   (fault_sts_o),
    .code_o  (fault_code_o)
  );

  assign trip = ovp_i | ocp_q;

  // Next-state: thermal first, then other faults reload, then expiry.
  always_comb begin
    st_d = st_q;
    load = 1'b0;
    ss_d = 1'b0;
    unique case (st_q)
      ST_RUN: begin
        if (temp_hot_i) begin
          st_d = ST_THERM;
          load = 1'b1;
        end else if (trip) begin
          st_d = ST_HOLD;
          load = 1'b1;
        end
      end
      ST_HOLD: begin
        if (temp_hot_i) begin
          st_d = ST_THERM;
          load = 1'b1;
        end else if (trip) begin
          load = 1'b1;
        end else if (expired) begin
          st_d = ST_RUN;
          ss_d = 1'b1;
        end
      end
      ST_THERM: begin
        if (trip) begin
          load = 1'b1;
        end else if (expired) begin
          if (temp_cool_i) begin
            st_d = ST_RUN;
            ss_d = 1'b1;
          end else begin
            load = 1'b1;
          end
        end
      end
      default: st_d = ST_RUN;
    endcase
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      st_q <= ST_RUN;
      ss_q <= 1'b0;
    end else begin
      st_q <= st_d;
      ss_q <= ss_d;
    end
  end

  assign sw_stop_o    = (st_q != ST_RUN) | trip | temp_hot_i;
  assign ss_req_o     = ss_q;
  assign therm_hold_o = (st_q == ST_THERM);

endmodule

// File: rtl/fault_restart_seq_chk.sv
module fault_restart_seq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       ovp_i,
  input logic       gate_on_i,
  input logic       ocp_raw_i,
  input logic       temp_hot_i,
  input logic       temp_cool_i,
  input logic       sts_clr_i,
  input logic       sw_stop_o,
  input logic       ss_req_o,
  input logic       therm_hold_o,
  input logic [2:0] fault_sts_o,
  input logic [1:0] fault_code_o
);

  // R1: a sampled supply or thermal fault keeps switching stopped next cycle
  p_fault_holds_stop_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (ovp_i || temp_hot_i) |=> sw_stop_o);

  // R2: over-current status can only appear after gate-on and raw sense
  p_ocp_needs_gate_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fault_sts_o[0]) |-> ($past(gate_on_i) && $past(ocp_raw_i)));

  // R4: a restart request follows a stopped cycle
  p_ss_after_stop_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ss_req_o |-> $past(sw_stop_o));

  // R4: restart request lasts a single cycle
  p_ss_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ss_req_o |=> !ss_req_o);

  // R6: leaving thermal lockout needs the release flag
  p_therm_release_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (ss_req_o && $past(therm_hold_o)) |-> $past(temp_cool_i));

  // R6: lockout always stops switching
  p_therm_stop_r6: assert property (@(posedge clk) disable iff (!rst_n)
    therm_hold_o |-> sw_stop_o);

  // R7: recorded bits survive unless cleared
  p_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !sts_clr_i |=> ((fault_sts_o & $past(fault_sts_o)) == $past(fault_sts_o)));

  // R8: an empty record reports no fault
  p_code_empty_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (fault_sts_o == 3'b000) |-> (fault_code_o == 2'd0));

endmodule

bind fault_restart_seq fault_restart_seq_chk u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .ovp_i        (ovp_i),
  .gate_on_i    (gate_on_i),
  .ocp_raw_i    (ocp_raw_i),
  .temp_hot_i   (temp_hot_i),
  .temp_cool_i  (temp_cool_i),
  .sts_clr_i    (sts_clr_i),
  .sw_stop_o    (sw_stop_o),
  .ss_req_o     (ss_req_o),
  .therm_hold_o (therm_hold_o),
  .fault_sts_o  (fault_sts_o),
  .fault_code_o (fault_code_o)
);

// File: tb/fault_restart_seq_tb_top.sv
`timescale 1ns/1ps
module fault_restart_seq_tb_top;

  localparam int LEB = 6;
  localparam int AR  = 40;

  logic       clk;
  logic       rst_n;
  logic       ovp_i;
  logic       gate_on_i;
  logic       ocp_raw_i;
  logic       temp_hot_i;
  logic       temp_cool_i;
  logic       sts_clr_i;
  logic       sw_stop_o;
  logic       ss_req_o;
  logic       therm_hold_o;
  logic [2:0] fault_sts_o;
  logic [1:0] fault_code_o;

  int n_chk;
  int n_fail;
  int cyc_cnt;
  bit cmp_en;

  fault_restart_seq #(.LEB_CYC(LEB), .AR_CYC(AR)) dut_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .ovp_i        (ovp_i),
    .gate_on_i    (gate_on_i),
    .ocp_raw_i    (ocp_raw_i),
    .temp_hot_i   (temp_hot_i),
    .temp_cool_i  (temp_cool_i),
    .sts_clr_i    (sts_clr_i),
    .sw_stop_o    (sw_stop_o),
    .ss_req_o     (ss_req_o),
    .therm_hold_o (therm_hold_o),
    .fault_sts_o  (fault_sts_o),
    .fault_code_o (fault_code_o)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // Behavioural reference: mode 0 run, 1 hold-off, 2 thermal lockout
  int       m_mode;
  int       m_left;
  int       m_gate_edges;
  bit [2:0] m_rec;
  bit       m_ss;
  bit       m_oc;
  bit       m_trip;
  bit       m_done;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_mode = 0; m_left = 0; m_gate_edges = 0; m_rec = 3'b000; m_ss = 1'b0;
    end else begin
      m_oc   = gate_on_i && ocp_raw_i && (m_gate_edges == LEB);
      m_trip = ovp_i || m_oc;
      m_done = (m_left == 0);
      if (sts_clr_i) m_rec = 3'b000;
      if (m_oc)       m_rec[0] = 1'b1;
      if (ovp_i)      m_rec[1] = 1'b1;
      if (temp_hot_i) m_rec[2] = 1'b1;
      if (m_left > 0) m_left = m_left - 1;
      m_ss = 1'b0;
      if (m_mode == 0) begin
        if (temp_hot_i)  begin m_mode = 2; m_left = AR - 1; end
        else if (m_trip) begin m_mode = 1; m_left = AR - 1; end
      end else if (m_mode == 1) begin
        if (temp_hot_i)  begin m_mode = 2; m_left = AR - 1; end
        else if (m_trip) m_left = AR - 1;
        else if (m_done) begin m_mode = 0; m_ss = 1'b1; end
      end else begin
        if (m_trip) m_left = AR - 1;
        else if (m_done) begin
          if (temp_cool_i) begin m_mode = 0; m_ss = 1'b1; end
          else m_left = AR - 1;
        end
      end
      if (!gate_on_i) m_gate_edges = 0;
      else if (m_gate_edges < LEB) m_gate_edges = m_gate_edges + 1;
    end
  end

  // Per-cycle comparison, away from the active edge
  always @(negedge clk) begin
    if (cmp_en) begin
      automatic bit e_oc   = gate_on_i && ocp_raw_i && (m_gate_edges == LEB);
      automatic bit e_stop = (m_mode != 0) || ovp_i || e_oc || temp_hot_i;
      automatic int e_code = m_rec[2] ? 3 : m_rec[1] ? 2 : m_rec[0] ? 1 : 0;
      chk("R1 stop", int'(sw_stop_o), int'(e_stop));
      chk("R4 soft-start", int'(ss_req_o), int'(m_ss));
      chk("R6 lockout", int'(therm_hold_o), int'(m_mode == 2));
      chk("R7 status", int'(fault_sts_o), int'(m_rec));
      chk("R8 code", int'(fault_code_o), e_code);
    end
  end

  always @(posedge clk) begin
    cyc_cnt++;
    if (cyc_cnt == 150000) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=%0d expected=<150000 cycles", cyc_cnt);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    #2;
  endtask

  task automatic count_stop(output int n, output bit ss_seen);
    n = 0;
    @(negedge clk);
    while (sw_stop_o && n < 10 * AR) begin
      n++;
      @(negedge clk);
    end
    ss_seen = ss_req_o;
    #3;
  endtask

  initial begin
    int  n;
    bit  ss;
    rst_n = 1'b0; ovp_i = 0; gate_on_i = 0; ocp_raw_i = 0;
    temp_hot_i = 0; temp_cool_i = 0; sts_clr_i = 0;
    n_chk = 0; n_fail = 0; cyc_cnt = 0; cmp_en = 0;
    step(4);
    rst_n = 1'b1;
    step(4);
    cmp_en = 1;
    @(negedge clk);
    // R9: reset state
    chk("R9 stop", int'(sw_stop_o), 0);
    chk("R9 ss", int'(ss_req_o), 0);
    chk("R9 status", int'(fault_sts_o), 0);
    chk("R9 code", int'(fault_code_o), 0);
    chk("R9 lockout", int'(therm_hold_o), 0);
    step(1);

    // R3/R4: single over-voltage pulse
    ovp_i = 1; step(1); ovp_i = 0;
    count_stop(n, ss);
    chk("R3 hold length", n, AR);
    chk("R4 restart pulse", int'(ss), 1);
    step(5);

    // R5: second fault inside hold-off reloads the interval
    ovp_i = 1; step(1); ovp_i = 0;
    step(10);
    ovp_i = 1; step(1); ovp_i = 0;
    count_stop(n, ss);
    chk("R5 reload length", n, AR);
    step(3);

    // R2: over-current inside blanking is ignored
    sts_clr_i = 1; step(1); sts_clr_i = 0;
    gate_on_i = 1; ocp_raw_i = 1;
    step(LEB - 1);
    gate_on_i = 0; ocp_raw_i = 0;
    step(2);
    @(negedge clk);
    chk("R2 blanked status", int'(fault_sts_o[0]), 0);
    chk("R2 blanked stop", int'(sw_stop_o), 0);
    step(1);
    // R2: over-current past blanking trips
    gate_on_i = 1; ocp_raw_i = 1;
    step(LEB + 1);
    gate_on_i = 0; ocp_raw_i = 0;
    @(negedge clk);
    chk("R2 qualified status", int'(fault_sts_o[0]), 1);
    chk("R2 qualified stop", int'(sw_stop_o), 1);
    count_stop(n, ss);
    step(3);

    // R6: thermal lockout persists while not cool
    temp_hot_i = 1; ovp_i = 1; step(1); temp_hot_i = 0; ovp_i = 0;
    step(2 * AR + 5);
    @(negedge clk);
    chk("R6 lockout held", int'(therm_hold_o), 1);
    chk("R8 both recorded", int'(fault_code_o), 3);
    step(1);
    temp_cool_i = 1;
    count_stop(n, ss);
    chk("R6 released", int'(therm_hold_o), 0);
    chk("R6 restart pulse", int'(ss), 1);
    temp_cool_i = 0;
    step(2);

    // R7: clear with simultaneous flag keeps that flag
    sts_clr_i = 1; ovp_i = 1; step(1); sts_clr_i = 0; ovp_i = 0;
    @(negedge clk);
    chk("R7 set beats clear", int'(fault_sts_o), 2);
    chk("R8 over-voltage code", int'(fault_code_o), 2);
    count_stop(n, ss);
    sts_clr_i = 1; step(1); sts_clr_i = 0;
    @(negedge clk);
    chk("R7 cleared", int'(fault_sts_o), 0);
    step(5);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule